// File: doc/BRIEF.md
# Upscaling Dual-Clock Framebuffer Source

This block is a pixel source for a display pipeline. It holds a coarse image of 40 by 30 words, 32 bits each, in a dual-clock memory. Each stored word covers a square of 16 by 16 screen pixels, so the coarse image fills a 640 by 480 raster. Software loads and inspects the image through a system port on its own clock. The video side runs on a separate pixel clock, presents the current column and line counters with an enable, and receives one registered pixel word per cycle.

The word fetched for a screen position is found by dividing the column by 16, dividing the line by 16, and adding the first quotient to forty times the second. The column is not clamped. A column past 639 therefore runs on into the next coarse row. A position whose computed word index lies past the end of the buffer reads as zero. So does any cycle in which the video enable is low.

Top module: `scaled_fb_source`

## Requirements
- R1: While the system reset is high, the system read data is zero one system-clock cycle later. While the video reset is high, the pixel output is zero one pixel-clock cycle later.
- R2: A system write with write enable high and address below 1200 stores the data at that clock edge. A system read returns the word at the applied address one system-clock cycle later, including a write made in the immediately preceding cycle.
- R3: A system cycle with write enable low leaves the buffer contents unchanged, whatever the write data and address.
- R4: With the video enable high, the pixel output one pixel-clock cycle after a column c and line l are presented is word (c/16) + (l/16)*40, using integer division.
- R5: All 256 screen positions inside one 16x16 block, with columns 0..639, return the same buffer word.
- R6: A column above 639 is not clamped. For example, column 640 on line 0 returns word 40, and column 656 on line 16 returns word 81.
- R7: With the video enable low, the pixel output is zero one pixel-clock cycle later, and the output returns to the stored word once the enable is high again.
- R8: Word indices of 1200 or more do not exist. A video position mapping to such an index outputs zero. A system write to such an address changes no word, including words whose index equals the address modulo 1200 or modulo 1024, and a system read of such an address returns zero.
- R9: A system write and a read of the same address in the same cycle return the word's old contents, and the new contents are returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System-side clock |
| sys_rst | input | 1 | System-side synchronous reset, active high |
| sys_addr | input | 11 | Buffer word address for reads and writes |
| sys_wdata | input | 32 | Write data |
| sys_we | input | 1 | Write enable |
| sys_rdata | output | 32 | Registered read data |
| pix_clk | input | 1 | Video-side clock |
| pix_rst | input | 1 | Video-side synchronous reset, active high |
| pix_en | input | 1 | Video output enable |
| pix_col | input | 11 | Current column counter |
| pix_row | input | 10 | Current line counter |
| pix_data | output | 32 | Registered pixel word |

## Verification
The buffer is filled with a distinct value in every word, so any addressing slip shows up as a wrong word. A coarse raster sweep with a step of 3 columns and 15 lines tests the division and row stride (R4, R5). Targeted positions around columns 639/640/656 and the last line separate clamping from wrapping (R6) and in-range from out-of-range indices (R8). Enable toggling inside a sweep tells blanking apart from stale output (R7). On the system side, back-to-back write/read, a same-cycle write/read, writes with the enable low and writes to aliased addresses beyond the buffer tell read-first timing, write gating and address range checking apart.

// File: rtl/scaled_fb_source.sv
module scaled_fb_source #(
  parameter int WORD_W      = 32,
  parameter int COARSE_COLS = 40,
  parameter int COARSE_ROWS = 30,
  parameter int SCALE_LOG2  = 4,
  parameter int COL_W       = 11,
  parameter int ROW_W       = 10,
  parameter int SYS_AW      = 11
) (
  input  logic              sys_clk,
  input  logic              sys_rst,
  input  logic [SYS_AW-1:0] sys_addr,
  input  logic [WORD_W-1:0] sys_wdata,
  input  logic              sys_we,
  output logic [WORD_W-1:0] sys_rdata,
  input  logic              pix_clk,
  input  logic              pix_rst,
  input  logic              pix_en,
  input  logic [COL_W-1:0]  pix_col,
  input  logic [ROW_W-1:0]  pix_row,
  output logic [WORD_W-1:0] pix_data
);
  localparam int DEPTH  = COARSE_COLS * COARSE_ROWS;
  localparam int MI_W   = $clog2(DEPTH);
  localparam int CC_W   = COL_W - SCALE_LOG2;
  localparam int CR_W   = ROW_W - SCALE_LOG2;
  localparam int VA_MAX = (2**CC_W - 1) + (2**CR_W - 1) * COARSE_COLS;
  localparam int VA_W   = $clog2(VA_MAX + 1);
  localparam int SA_W   = (SYS_AW > MI_W) ? SYS_AW : MI_W;

  logic [WORD_W-1:0] mem [DEPTH];

  logic [CC_W-1:0] coarse_col;
  logic [CR_W-1:0] coarse_row;
  logic [VA_W-1:0] vaddr;
  logic            v_ok;
  logic [SA_W-1:0] saddr;
  logic            s_ok;

  assign coarse_col = pix_col[COL_W-1:SCALE_LOG2];
  assign coarse_row = pix_row[ROW_W-1:SCALE_LOG2];
  assign vaddr = VA_W'(coarse_col) + VA_W'(coarse_row) * VA_W'(COARSE_COLS);
  assign v_ok  = 32'(vaddr) < DEPTH;
  assign saddr = SA_W'(sys_addr);
  assign s_ok  = 32'(saddr) < DEPTH;

  always_ff @(posedge sys_clk) begin
    if (sys_we && s_ok) mem[MI_W'(saddr)] <= sys_wdata;
  end

  always_ff @(posedge sys_clk) begin
    if (sys_rst)   sys_rdata <= '0;
    else if (s_ok) sys_rdata <= mem[MI_W'(saddr)];
    else           sys_rdata <= '0;
  end

  always_ff @(posedge pix_clk) begin
    if (pix_rst)            pix_data <= '0;
    else if (pix_en && v_ok) pix_data <= mem[MI_W'(vaddr)];
    else                    pix_data <= '0;
  end
endmodule

module scaled_fb_source_chk #(
  parameter int WORD_W      = 32,
  parameter int COARSE_COLS = 40,
  parameter int COARSE_ROWS = 30,
  parameter int SCALE_LOG2  = 4,
  parameter int COL_W       = 11,
  parameter int ROW_W       = 10,
  parameter int SYS_AW      = 11
) (
  input logic              sys_clk,
  input logic              sys_rst,
  input logic [SYS_AW-1:0] sys_addr,
  input logic [WORD_W-1:0] sys_wdata,
  input logic              sys_we,
  input logic [WORD_W-1:0] sys_rdata,
  input logic              pix_clk,
  input logic              pix_rst,
  input logic              pix_en,
  input logic [COL_W-1:0]  pix_col,
  input logic [ROW_W-1:0]  pix_row,
  input logic [WORD_W-1:0] pix_data
);
  localparam int DEPTH = COARSE_COLS * COARSE_ROWS;

  logic [31:0] chk_idx;
  assign chk_idx = 32'(pix_col >> SCALE_LOG2) + 32'(pix_row >> SCALE_LOG2) * 32'(COARSE_COLS);

  assert_sys_reset_R1: assert property (@(posedge sys_clk) sys_rst |=> sys_rdata == '0);
  assert_pix_reset_R1: assert property (@(posedge pix_clk) pix_rst |=> pix_data == '0);

  assert_wr_then_rd_R2: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (sys_we && 32'(sys_addr) < DEPTH) ##1 (!sys_we && sys_addr == $past(sys_addr))
    |=> sys_rdata == $past(sys_wdata, 2));

  assert_blank_R7: assert property (@(posedge pix_clk) disable iff (pix_rst)
    !pix_en |=> pix_data == '0);

  assert_vid_range_R8: assert property (@(posedge pix_clk) disable iff (pix_rst)
    (pix_en && chk_idx >= 32'(DEPTH)) |=> pix_data == '0);

  assert_sys_range_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (32'(sys_addr) >= DEPTH) |=> sys_rdata == '0);
endmodule

bind scaled_fb_source scaled_fb_source_chk #(
  .WORD_W(WORD_W), .COARSE_COLS(COARSE_COLS), .COARSE_ROWS(COARSE_ROWS),
  .SCALE_LOG2(SCALE_LOG2), .COL_W(COL_W), .ROW_W(ROW_W), .SYS_AW(SYS_AW)
) u_chk (
  .sys_clk(sys_clk), .sys_rst(sys_rst), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
  .sys_we(sys_we), .sys_rdata(sys_rdata), .pix_clk(pix_clk), .pix_rst(pix_rst),
  .pix_en(pix_en), .pix_col(pix_col), .pix_row(pix_row), .pix_data(pix_data)
);

// File: tb/scaled_fb_source_bench.sv
module scaled_fb_source_bench;
  logic        sys_clk = 0, pix_clk = 0;
  logic        sys_rst = 1, pix_rst = 1;
  logic [10:0] sys_addr = '0;
  logic [31:0] sys_wdata = '0;
  logic        sys_we = 0;
  logic [31:0] sys_rdata;
  logic        pix_en = 0;
  logic [10:0] pix_col = '0;
  logic [9:0]  pix_row = '0;
  logic [31:0] pix_data;

  always #2.5 sys_clk = ~sys_clk;
  always #4   pix_clk = ~pix_clk;

  scaled_fb_source u_scaled_fb_source (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_we(sys_we), .sys_rdata(sys_rdata), .pix_clk(pix_clk), .pix_rst(pix_rst),
    .pix_en(pix_en), .pix_col(pix_col), .pix_row(pix_row), .pix_data(pix_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] model [1200];
  logic [31:0] sq_exp[$], vq_exp[$];
  string       sq_tag[$], vq_tag[$];

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] pattern(int i);
    return 32'hA5000000 ^ (32'(i) * 32'h00010007) ^ 32'(i);
  endfunction

  function automatic logic [31:0] vexp(int c, int r, bit en);
    int a;
    a = c / 16 + (r / 16) * 40;
    if (!en || a >= 1200) return 32'h0;
    return model[a];
  endfunction

  task automatic sys_op(int a, bit we, logic [31:0] d, bit check, logic [31:0] e, string tag);
    @(negedge sys_clk);
    sys_addr = 11'(a); sys_we = we; sys_wdata = d;
    if (check) begin sq_exp.push_back(e); sq_tag.push_back(tag); end
    if (we && a < 1200) model[a] = d;
  endtask

  task automatic sys_read(int a, logic [31:0] e, string tag);
    sys_op(a, 0, 32'hDEAD0000, 1, e, tag);
  endtask

  task automatic vid(int c, int r, bit en, string tag);
    @(negedge pix_clk);
    pix_col = 11'(c); pix_row = 10'(r); pix_en = en;
    vq_exp.push_back(vexp(c, r, en)); vq_tag.push_back(tag);
  endtask

  initial forever begin
    @(posedge sys_clk); #1;
    if (sq_exp.size() > 0) chk(sq_tag.pop_front(), sys_rdata, sq_exp.pop_front());
  end

  initial forever begin
    @(posedge pix_clk); #1;
    if (vq_exp.size() > 0) chk(vq_tag.pop_front(), pix_data, vq_exp.pop_front());
  end

  initial begin
    #500us;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge pix_clk);
    chk("R1", sys_rdata, 32'h0);
    chk("R1", pix_data, 32'h0);
    sys_rst = 0;
    @(negedge pix_clk); pix_rst = 0;

    for (int i = 0; i < 1200; i++) sys_op(i, 1, pattern(i), 0, 0, "R2");
    foreach (model[i]) if (i % 97 == 0 || i == 39 || i == 40 || i == 1199) sys_read(i, model[i], "R2");

    sys_op(10, 1, 32'h0BAD_F00D, 0, 0, "R2");
    sys_read(10, 32'h0BAD_F00D, "R2");

    sys_op(20, 1, 32'h1234_5678, 1, pattern(20), "R9");
    sys_read(20, 32'h1234_5678, "R9");

    sys_op(30, 0, 32'hFFFF_FFFF, 0, 0, "R3");
    sys_read(30, pattern(30), "R3");

    sys_op(1500, 1, 32'hCAFE_CAFE, 0, 0, "R8");
    sys_read(1500, 32'h0, "R8");
    sys_read(300, pattern(300), "R8");
    sys_read(476, pattern(476), "R8");
    sys_read(1199, pattern(1199), "R8");

    repeat (3) @(negedge sys_clk);

    for (int r = 0; r < 480; r += 15)
      for (int c = 0; c < 704; c += 3) vid(c, r, 1, "R4");
    for (int c = 0; c < 704; c += 7) vid(c, 479, 1, "R4");

    for (int r = 32; r < 48; r++)
      for (int c = 160; c < 176; c++) vid(c, r, 1, "R5");

    vid(639, 0, 1, "R6");
    vid(640, 0, 1, "R6");
    vid(655, 15, 1, "R6");
    vid(656, 16, 1, "R6");
    vid(1023, 0, 1, "R6");

    for (int k = 0; k < 40; k++) vid(k * 16, 100, (k % 3) != 0, "R7");
    vid(200, 200, 0, "R7");
    vid(200, 200, 1, "R7");

    vid(639, 479, 1, "R8");
    vid(640, 479, 1, "R8");
    vid(1000, 479, 1, "R8");
    vid(2047, 479, 1, "R8");
    vid(0, 1023, 1, "R8");

    repeat (4) @(negedge pix_clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule